// File: doc/BRIEF.md
# Multi-pipe receive address matcher

This block decides whether the address field of an incoming packet belongs to one of six receive pipes and, if so, which one. Address bytes arrive one per strobe, least-significant byte first, with a flag on the first byte of each address. Once the configured number of bytes has been taken, the block gives a one-cycle completion pulse. In the same cycle it reports a hit flag and a 3-bit pipe number.

Pipes 0 and 1 each hold a full 40-bit address. Pipes 2 to 5 each store only a low byte, and their upper 32 bits come from pipe 1. The compare length comes from a 2-bit width code: 3, 4 or 5 bytes. A code of 00 is illegal and never produces a hit. Each pipe has its own enable bit. When several enabled pipes match, the lowest-numbered pipe is reported. The configuration registers sit behind a simple write port and a combinational read port. That port also holds the transmit address register, which the receive side needs to equal on pipe 0 for acknowledgements to return.

Top module: `pipe_addr_matcher`

## Requirements
- R1: After reset the registers read back as follows: pipe enables at offset 0x02 read 0x03, the width code at 0x03 reads 3, pipe 0 at 0x0A reads 0xE7E7E7E7E7, pipe 1 at 0x0B reads 0xC2C2C2C2C2, pipes 2 to 5 at 0x0C to 0x0F read 0xC3, 0xC4, 0xC5 and 0xC6, and the transmit address at 0x10 reads 0xE7E7E7E7E7. Any other offset reads zero. Read data is zero-extended to 40 bits.
- R2: A cycle with `cfg_we` high writes `cfg_wdata` to the register at `cfg_waddr`. The register keeps the low 6 bits for the enables, the low 2 bits for the width code, the low 8 bits for pipes 2 to 5, and all 40 bits otherwise. The new value reads back from the next cycle on.
- R3: Byte k of an address, counted from 0 in arrival order, is compared with bits 8k+7:8k of the pipe address.
- R4: Width code 01 selects 3 bytes, 10 selects 4 bytes and 11 selects 5 bytes. The code is taken when the first byte arrives. `match_done` is high for exactly one cycle, starting with the clock edge that takes the last byte, and never earlier.
- R5: For pipes 2 to 5, byte 0 is compared with that pipe's stored low byte and bytes 1 to 4 are compared with bits 39:8 of pipe 1.
- R6: A pipe whose enable bit (bit N for pipe N) is 0 never produces a hit.
- R7: When more than one enabled pipe matches, the lowest-numbered pipe is reported.
- R8: With width code 00, `match_done` pulses after 3 bytes and `match_hit` stays 0.
- R9: During `match_done`, `match_pipe` is 0 to 5 with `match_hit` high on a hit, and 7 with `match_hit` low on a miss. Outside `match_done` (and after reset), `match_hit` is 0 and `match_pipe` is 7.
- R10: A byte with `in_first` high always starts a new address, even in the middle of another one. Bytes without `in_first` while no address is in progress are ignored and produce no `match_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 5 | Register write offset |
| cfg_wdata | input | 40 | Register write data |
| cfg_raddr | input | 5 | Register read offset |
| cfg_rdata | output | 40 | Register read data (combinational) |
| in_valid | input | 1 | Address byte strobe |
| in_first | input | 1 | Marks the first byte of an address |
| in_byte | input | 8 | Address byte, least-significant first |
| match_done | output | 1 | One-cycle pulse after the last address byte |
| match_hit | output | 1 | An enabled pipe matched (valid with match_done) |
| match_pipe | output | 3 | Winning pipe number, 7 when there is no hit |

## Verification
A running per-pipe compare flag stuck high or low shows up as a wrong hit or a wrong pipe number on the very frame that exercises that pipe. A wrong byte counter or a wrong latched length shows up as `match_done` arriving one or more strobes early or late. This is checked by sampling `match_done` after each partial byte of 4-byte and 5-byte addresses. A wrong register value or a faulty shared-byte path for pipes 2 to 5 shows up either at the read port in the next cycle or as a missed hit on the next frame. The random frames are built from the current pipe addresses with one byte corrupted now and then, so most faults show within a few dozen frames.

// File: rtl/pam_pkg.sv
// Package: shared constants, register offsets, reset values and the
// width-code decode for the receive address matcher.
// Assumes: addresses of at most 5 bytes, at most 8 pipes (3-bit pipe number).
package pam_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 5;
    localparam int ADDR_W     = BYTE_W * MAX_BYTES;
    localparam int NUM_PIPES  = 6;
    localparam int PIPE_W     = 3;
    localparam int CFG_AW     = 5;
    localparam int CNT_W      = 3;

    // Register offsets used by the driver software
    localparam logic [CFG_AW-1:0] OFS_ENABLE = 5'h02;
    localparam logic [CFG_AW-1:0] OFS_WIDTH  = 5'h03;
    localparam logic [CFG_AW-1:0] OFS_FULL0  = 5'h0A;
    localparam logic [CFG_AW-1:0] OFS_FULL1  = 5'h0B;
    localparam logic [CFG_AW-1:0] OFS_LOW2   = 5'h0C;
    localparam logic [CFG_AW-1:0] OFS_TXADR  = 5'h10;

    // Reset values
    localparam logic [ADDR_W-1:0] RST_FULL0  = 40'hE7E7E7E7E7;
    localparam logic [ADDR_W-1:0] RST_FULL1  = 40'hC2C2C2C2C2;
    localparam logic [ADDR_W-1:0] RST_TXADR  = 40'hE7E7E7E7E7;
    localparam int                RST_LOW2   = 'hC3;
    localparam logic [NUM_PIPES-1:0] RST_ENABLE = 6'h03;

    localparam logic [PIPE_W-1:0] NO_PIPE = 3'd7;

    typedef enum logic [1:0] {
        WIDTH_BAD = 2'b00,
        WIDTH_3   = 2'b01,
        WIDTH_4   = 2'b10,
        WIDTH_5   = 2'b11
    } width_code_t;

    // Compare length in bytes; the illegal code still spans 3 bytes
    function automatic logic [CNT_W-1:0] width_len(input logic [1:0] code);
        case (code)
            WIDTH_4: width_len = 3'd4;
            WIDTH_5: width_len = 3'd5;
            default: width_len = 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/pam_cfg_regs.sv
// Configuration registers: pipe enables, width code, two full-width pipe
// addresses, low bytes for the remaining pipes and the transmit address.
// Presents every pipe's effective address: pipes 2 and up take their upper
// bytes from pipe 1. Assumes NUM_PIPES >= 2.
module pam_cfg_regs
    import pam_pkg::*;
#(
    parameter int N_PIPES = NUM_PIPES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             waddr,
    input  logic [ADDR_W-1:0]             wdata,
    input  logic [CFG_AW-1:0]             raddr,
    output logic [ADDR_W-1:0]             rdata,
    output logic [N_PIPES-1:0]            pipe_en,
    output logic [1:0]                    width_code,
    output logic [N_PIPES-1:0][ADDR_W-1:0] pipe_addr
);

    localparam int N_LOW = N_PIPES - 2;

    logic [ADDR_W-1:0]            full0_q;
    logic [ADDR_W-1:0]            full1_q;
    logic [ADDR_W-1:0]            txadr_q;
    logic [N_PIPES-1:0]           en_q;
    logic [1:0]                   width_q;
    logic [N_LOW-1:0][BYTE_W-1:0] low_q;

    // Shared registers: enables, width, full addresses, transmit address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= RST_ENABLE;
            width_q <= WIDTH_5;
            full0_q <= RST_FULL0;
            full1_q <= RST_FULL1;
            txadr_q <= RST_TXADR;
        end else if (we) begin
            case (waddr)
                OFS_ENABLE: en_q    <= wdata[N_PIPES-1:0];
                OFS_WIDTH:  width_q <= wdata[1:0];
                OFS_FULL0:  full0_q <= wdata;
                OFS_FULL1:  full1_q <= wdata;
                OFS_TXADR:  txadr_q <= wdata;
                default: ;
            endcase
        end
    end

    // One low-byte register per shared-prefix pipe, each with its own reset value
    for (genvar p = 0; p < N_LOW; p++) begin : g_low
        localparam logic [CFG_AW-1:0] MY_OFS = CFG_AW'(int'(OFS_LOW2) + p);
        always_ff @(posedge clk) begin
            if (!rst_n)
                low_q[p] <= BYTE_W'(RST_LOW2 + p);
            else if (we && waddr == MY_OFS)
                low_q[p] <= wdata[BYTE_W-1:0];
        end
        assign pipe_addr[p+2] = {full1_q[ADDR_W-1:BYTE_W], low_q[p]};
    end

    assign pipe_addr[0] = full0_q;
    assign pipe_addr[1] = full1_q;
    assign pipe_en      = en_q;
    assign width_code   = width_q;

    // Read mux: zero-extended register contents, zero for unmapped offsets
    always_comb begin
        rdata = '0;
        case (raddr)
            OFS_ENABLE: rdata[N_PIPES-1:0] = en_q;
            OFS_WIDTH:  rdata[1:0]         = width_q;
            OFS_FULL0:  rdata              = full0_q;
            OFS_FULL1:  rdata              = full1_q;
            OFS_TXADR:  rdata              = txadr_q;
            default: begin
                for (int p = 0; p < N_LOW; p++) begin
                    if (int'(raddr) == int'(OFS_LOW2) + p)
                        rdata[BYTE_W-1:0] = low_q[p];
                end
            end
        endcase
    end

endmodule

// File: rtl/pam_byte_cmp.sv
// Per-pipe byte comparator. Keeps a running "all bytes so far equal" flag
// and reports whether the address, including the current byte, matches.
// Assumes byte_idx is 0 whenever first is high.
module pam_byte_cmp
    import pam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              first,
    input  logic [CNT_W-1:0]  byte_idx,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              full_ok
);

    logic [BYTE_W-1:0] ref_byte;
    logic              eq_now;
    logic              run_ok_q;

    // Select the reference byte for the current position
    always_comb begin
        ref_byte = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (int'(byte_idx) == k)
                ref_byte = ref_addr[k*BYTE_W +: BYTE_W];
        end
    end

    assign eq_now = (byte_in == ref_byte);

    // Running equality over the bytes taken so far
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_ok_q <= 1'b0;
        else if (step)
            run_ok_q <= first ? eq_now : (run_ok_q & eq_now);
    end

    assign full_ok = eq_now & (first | run_ok_q);

endmodule

// File: rtl/pam_prio_pick.sv
// Fixed-priority picker: lowest-numbered candidate wins; NO_PIPE when none.
module pam_prio_pick
    import pam_pkg::*;
#(
    parameter int N_CAND = NUM_PIPES
) (
    input  logic [N_CAND-1:0] cand,
    output logic              any,
    output logic [PIPE_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last
    always_comb begin
        idx = NO_PIPE;
        for (int p = N_CAND - 1; p >= 0; p--) begin
            if (cand[p])
                idx = PIPE_W'(p);
        end
    end

    assign any = |cand;

endmodule

// File: rtl/pipe_addr_matcher.sv
// Top: receive address matcher. Counts address bytes of a frame (started by
// in_first), runs a comparator per pipe and registers a one-cycle result
// once the configured number of bytes has been taken.
// Assumes the minimum address length (3) exceeds 1, so the first byte is
// never the last.
module pipe_addr_matcher
    import pam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_waddr,
    input  logic [39:0]       cfg_wdata,
    input  logic [4:0]        cfg_raddr,
    output logic [39:0]       cfg_rdata,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [7:0]        in_byte,
    output logic              match_done,
    output logic              match_hit,
    output logic [2:0]        match_pipe
);

    logic [NUM_PIPES-1:0]             pipe_en;
    logic [1:0]                       width_code;
    logic [NUM_PIPES-1:0][ADDR_W-1:0] pipe_addr;
    logic [NUM_PIPES-1:0]             full_ok;
    logic [NUM_PIPES-1:0]             cand;
    logic                             any_hit;
    logic [PIPE_W-1:0]                win_idx;

    logic                             active_q;
    logic [CNT_W-1:0]                 cnt_q;
    logic [CNT_W-1:0]                 len_q;
    logic                             legal_q;

    logic                             step;
    logic [CNT_W-1:0]                 cur_idx;
    logic [CNT_W-1:0]                 cur_len;
    logic                             cur_legal;
    logic                             last_byte;

    pam_cfg_regs #(.N_PIPES(NUM_PIPES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .waddr      (cfg_waddr),
        .wdata      (cfg_wdata),
        .raddr      (cfg_raddr),
        .rdata      (cfg_rdata),
        .pipe_en    (pipe_en),
        .width_code (width_code),
        .pipe_addr  (pipe_addr)
    );

    // Frame position: a first byte restarts, other bytes count only in a frame
    assign step      = in_valid & (in_first | active_q);
    assign cur_idx   = in_first ? '0 : cnt_q;
    assign cur_len   = in_first ? width_len(width_code) : len_q;
    assign cur_legal = in_first ? (width_code != WIDTH_BAD) : legal_q;
    assign last_byte = step & (cur_idx == cur_len - 3'd1);

    // Byte counter and per-frame latched width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            len_q    <= 3'd5;
            legal_q  <= 1'b1;
        end else if (in_valid && in_first) begin
            active_q <= 1'b1;
            cnt_q    <= 3'd1;
            len_q    <= width_len(width_code);
            legal_q  <= (width_code != WIDTH_BAD);
        end else if (step) begin
            if (last_byte) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 3'd1;
            end
        end
    end

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_cmp
        pam_byte_cmp u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .first    (in_first),
            .byte_idx (cur_idx),
            .byte_in  (in_byte),
            .ref_addr (pipe_addr[p]),
            .full_ok  (full_ok[p])
        );
    end

    assign cand = full_ok & pipe_en;

    pam_prio_pick #(.N_CAND(NUM_PIPES)) u_pick (
        .cand (cand),
        .any  (any_hit),
        .idx  (win_idx)
    );

    // Registered one-cycle result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_done <= 1'b0;
            match_hit  <= 1'b0;
            match_pipe <= NO_PIPE;
        end else begin
            match_done <= last_byte;
            match_hit  <= last_byte & cur_legal & any_hit;
            match_pipe <= (last_byte && cur_legal && any_hit) ? win_idx : NO_PIPE;
        end
    end

endmodule

// File: rtl/pam_checker.sv
// Checker for the receive address matcher, attached by bind.
module pam_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       hit,
    input logic [2:0] pipe,
    input logic [5:0] en
);

    // R9
    hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> done);

    // R9
    miss_pipe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> pipe == 3'd7);

    // R4
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    hit_pipe_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pipe < 3'd6) && (($past(en) >> pipe) & 6'd1) == 6'd1);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !hit && pipe == 3'd7));

endmodule

bind pipe_addr_matcher pam_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (match_done),
    .hit   (match_hit),
    .pipe  (match_pipe),
    .en    (pipe_en)
);

// File: tb/sim_pipe_addr_matcher.sv
`timescale 1ns/1ps
module sim_pipe_addr_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_waddr = '0;
    logic [39:0] cfg_wdata = '0;
    logic [4:0]  cfg_raddr = '0;
    logic [39:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        match_done;
    logic        match_hit;
    logic [2:0]  match_pipe;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pipe_addr_matcher u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
        .match_done(match_done), .match_hit(match_hit), .match_pipe(match_pipe)
    );

    // Reference model of the register contents (from R1/R2)
    logic [39:0] m_full0, m_full1, m_tx;
    logic [7:0]  m_low [2:5];
    logic [5:0]  m_en;
    logic [1:0]  m_aw;

    task automatic model_reset();
        m_full0 = 40'hE7E7E7E7E7; m_full1 = 40'hC2C2C2C2C2; m_tx = 40'hE7E7E7E7E7;
        for (int p = 2; p < 6; p++) m_low[p] = 8'(8'hC3 + p - 2);
        m_en = 6'h03; m_aw = 2'b11;
    endtask

    function automatic logic [39:0] m_addr(int p);
        if (p == 0) return m_full0;
        if (p == 1) return m_full1;
        return {m_full1[39:8], m_low[p]};
    endfunction

    function automatic int m_len(logic [1:0] c);
        return (c == 2'b10) ? 4 : (c == 2'b11) ? 5 : 3;
    endfunction

    // Expected pipe for a frame (R3..R9): 7 means miss
    function automatic logic [2:0] m_expect(logic [39:0] a);
        logic [39:0] mask;
        if (m_aw == 2'b00) return 3'd7;
        mask = (40'h1 << (8 * m_len(m_aw))) - 40'h1;
        for (int p = 0; p < 6; p++)
            if (m_en[p] && ((a & mask) == (m_addr(p) & mask))) return 3'(p);
        return 3'd7;
    endfunction

    task automatic check(string req, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            5'h02: m_en = d[5:0];
            5'h03: m_aw = d[1:0];
            5'h0A: m_full0 = d;
            5'h0B: m_full1 = d;
            5'h10: m_tx = d;
            5'h0C, 5'h0D, 5'h0E, 5'h0F: m_low[int'(a) - 12 + 2] = d[7:0];
            default: ;
        endcase
    endtask

    task automatic rd_check(string req, logic [4:0] a, logic [39:0] exp);
        cfg_raddr = a;
        #0.5;
        check(req, cfg_rdata, exp);
    endtask

    task automatic push(logic [7:0] b, logic f);
        @(negedge clk);
        in_valid = 1'b1; in_first = f; in_byte = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    // Send a whole frame and check result and single-cycle pulse
    task automatic frame(string req, logic [39:0] a, int n, logic [2:0] exp);
        for (int k = 0; k < n; k++) push(a[8*k +: 8], k == 0);
        idle();
        check({req, " done"}, {39'b0, match_done}, 40'd1);
        check({req, " hit"}, {39'b0, match_hit}, {39'b0, exp != 3'd7});
        check({req, " pipe"}, {37'b0, match_pipe}, {37'b0, exp});
        @(negedge clk);
        check({req, " done pulse ends"}, {39'b0, match_done}, 40'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [39:0] a;
        logic [2:0]  e;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9 reset state
        check("R9 reset done", {39'b0, match_done}, 40'd0);
        check("R9 reset pipe", {37'b0, match_pipe}, 40'd7);
        rd_check("R1 enables", 5'h02, 40'h03);
        rd_check("R1 width", 5'h03, 40'h03);
        rd_check("R1 pipe0", 5'h0A, 40'hE7E7E7E7E7);
        rd_check("R1 pipe1", 5'h0B, 40'hC2C2C2C2C2);
        for (int p = 2; p < 6; p++) rd_check("R1 low byte", 5'(12 + p - 2), 40'(8'hC3 + p - 2));
        rd_check("R1 txaddr", 5'h10, 40'hE7E7E7E7E7);
        rd_check("R1 unmapped", 5'h05, 40'h0);

        // R3 default addresses, 5 bytes
        frame("R3 pipe1 default", 40'hC2C2C2C2C2, 5, 3'd1);
        frame("R3 pipe0 default", 40'hE7E7E7E7E7, 5, 3'd0);
        // R2 write / readback, R3 byte order
        wr(5'h0B, 40'h1122334455);
        rd_check("R2 pipe1 readback", 5'h0B, 40'h1122334455);
        wr(5'h0E, 40'hFFFFFFFFA7);
        rd_check("R2 low byte masked", 5'h0E, 40'hA7);
        wr(5'h02, 40'hFFFFFFFFFF);
        rd_check("R2 enables masked", 5'h02, 40'h3F);
        frame("R3 lsb first", 40'h1122334455, 5, 3'd1);
        frame("R3 reversed misses", 40'h5544332211, 5, 3'd7);

        // R5 shared upper bytes
        frame("R5 pipe3", {40'h1122334455 & 40'hFFFFFFFF00} | 40'hC4, 5, 3'd3);
        frame("R5 pipe4", 40'h11223344A7, 5, 3'd4);
        frame("R5 upper byte differs", 40'h99223344C4, 5, 3'd7);

        // R4 width 4: no done after 3 bytes
        wr(5'h03, 40'h2);
        push(8'h55, 1'b1); push(8'h44, 1'b0); push(8'h33, 1'b0); idle();
        check("R4 no early done", {39'b0, match_done}, 40'd0);
        push(8'h22, 1'b0); idle();
        check("R4 done after 4", {39'b0, match_done}, 40'd1);
        check("R4 pipe after 4", {37'b0, match_pipe}, 40'd1);
        frame("R4 width4 ignores byte4", 40'hEE22334455, 4, 3'd1);
        wr(5'h03, 40'h1);
        frame("R4 width3", 40'hAAAA334455, 3, 3'd1);
        wr(5'h03, 40'h3);
        push(8'h55, 1'b1); push(8'h44, 1'b0); push(8'h33, 1'b0); push(8'h22, 1'b0); idle();
        check("R4 no done after 4 of 5", {39'b0, match_done}, 40'd0);
        push(8'h11, 1'b0); idle();
        check("R4 done after 5", {39'b0, match_done}, 40'd1);

        // R6 disabled pipe
        wr(5'h02, 40'h3D);
        frame("R6 pipe1 disabled", 40'h1122334455, 5, 3'd7);
        // R7 priority
        wr(5'h02, 40'h3F);
        wr(5'h0A, 40'h1122334455);
        frame("R7 pipe0 over pipe1", 40'h1122334455, 5, 3'd0);
        wr(5'h0C, 40'h55);
        wr(5'h02, 40'h3E);
        frame("R7 pipe1 over pipe2", 40'h1122334455, 5, 3'd1);
        wr(5'h0F, 40'hA7);
        wr(5'h02, 40'h30);
        frame("R7 pipe4 over pipe5", 40'h11223344A7, 5, 3'd4);

        // R8 illegal width
        wr(5'h02, 40'h3F);
        wr(5'h03, 40'h0);
        rd_check("R8 width readback", 5'h03, 40'h0);
        frame("R8 illegal no hit", 40'h1122334455, 3, 3'd7);
        wr(5'h03, 40'h3);

        // R10 stray bytes ignored, restart on first
        for (int k = 0; k < 6; k++) begin
            push(8'h55, 1'b0); idle();
            check("R10 stray byte no done", {39'b0, match_done}, 40'd0);
        end
        push(8'h00, 1'b1); push(8'h01, 1'b0);
        frame("R10 restart mid-frame", 40'h1122334455, 5, 3'd0);

        // Random frames against the model
        for (int i = 0; i < 400; i++) begin
            if (i % 25 == 0) begin
                wr(5'h02, 40'($urandom()));
                wr(5'h03, 40'(($urandom() % 8 == 0) ? 0 : 1 + $urandom() % 3));
                wr(5'h0A, {8'($urandom()), 32'($urandom())});
                wr(5'h0B, {8'($urandom()), 32'($urandom())});
                wr(5'(12 + $urandom() % 4), 40'($urandom()));
            end
            a = m_addr(int'($urandom() % 6));
            if ($urandom() % 3 == 0) a[8 * ($urandom() % 5) +: 8] ^= 8'(1 + $urandom() % 255);
            if ($urandom() % 10 == 0) a = {8'($urandom()), 32'($urandom())};
            e = m_expect(a);
            frame("R7 random frame", a, m_len(m_aw), e);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial void'($urandom(32'd12345));

endmodule